// File: doc/BRIEF.md
# Microprogram Sequencer With Subroutine Stack

This block produces, every clock cycle, the address of the next microinstruction for the control store of a microcoded processor. The current microword supplies a 2-bit source selector and chooses one of four origins for that address. The first is the microprogram counter, which steps through microcode in order. The second is a branch target carried in the microword. The third is the top of a four-entry return-address stack, used to come back from a microsubroutine. The fourth is a dispatch address derived from the instruction register, used to jump to the microcode routine for an opcode.

A branch can be made conditional. One of eight condition inputs is chosen by a 3-bit field. When that input is low, the branch is not taken and the sequencer steps to the next address in order. Two microword bits command push and pop on the return stack. A call pushes the address that follows the calling microinstruction. A return selects the stack source and pops in the same cycle.

Stack occupancy is tracked by a three-state machine. Its states are EMPTY, PARTIAL and FULL, and a level count runs alongside it. The transitions are:
- EMPTY to PARTIAL on a push, or on a simultaneous push and pop.
- PARTIAL to PARTIAL on a push that leaves a free slot, on a pop from two or more entries, and on a replace.
- PARTIAL to FULL on the push that fills the last slot.
- PARTIAL to EMPTY on a pop from a single entry.
- FULL to PARTIAL on any pop.
- FULL to FULL on a push (wrap-overwrite) and on a replace.
- Any other command (hold) leaves the state where it is.

Top module: `msq_sequencer`

## Requirements
- R1: `src_sel` picks the next address. Value 0 picks the microprogram counter, 1 the branch address, 2 the stack top, and 3 `dispatch_addr`.
- R2: While `rst_n` is low, `next_addr` is 0 whatever the other inputs are. The stack is emptied and all its entries are cleared to 0. After release, source 0 yields 1 and source 2 yields 0.
- R3: The microprogram counter takes the value of `next_addr` plus one on every clock edge out of reset, wrapping modulo 256.
- R4: With `src_sel`=1, the branch is taken when `cond_en` is 0, or when `cond_in[cond_sel]` is 1. Otherwise `next_addr` equals the microprogram counter.
- R5: A push stores the microprogram counter value, which is the current address plus one. That value becomes the new stack top.
- R6: A pop removes the top, and the previous entry becomes the top, in last-in first-out order four deep.
- R7: A push onto a full stack drops the oldest entry, stores the new one on top, and the stack stays full.
- R8: When the stack is empty, a pop changes nothing, and the stack source yields the entry most recently removed.
- R9: A push and a pop in the same cycle overwrite the top entry with the microprogram counter. On a non-empty stack the level is unchanged.
- R10: `stk_full` is 1 exactly when four entries are held, and `stk_empty` is 1 exactly when none are.
- R11: With `src_sel`=2, `next_addr` is the top as it stood before that cycle's push or pop takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Next-address source: 0 counter, 1 branch, 2 stack, 3 dispatch |
| cond_en | input | 1 | Make the branch conditional |
| cond_sel | input | 3 | Index of the condition input to test |
| cond_in | input | 8 | Condition inputs |
| branch_addr | input | 8 | Branch target from the microword |
| dispatch_addr | input | 8 | Opcode-derived dispatch target |
| stk_push | input | 1 | Push the counter value onto the stack |
| stk_pop | input | 1 | Pop the stack |
| next_addr | output | 8 | Next microinstruction address |
| stk_full | output | 1 | Stack holds four entries |
| stk_empty | output | 1 | Stack holds no entries |

## Verification
The hardest state to reach from the ports is a wrapped stack. Here a fifth push has dropped the oldest return address, and the stack must then be unwound past that point to show what survives. The stimulus calls and returns two levels deep and then underflows. It next pushes five times in a row from consecutive counter addresses, so each stored value is predictable. It then pops four times, expecting the first value pushed to be gone and the fourth pop to leave the stack empty. A final stack read on the empty stack returns the last entry removed.

// File: rtl/msq_pkg.sv
`timescale 1ns/1ps
package msq_pkg;

    typedef enum logic [1:0] {
        NS_UPC      = 2'd0,
        NS_BRANCH   = 2'd1,
        NS_STACK    = 2'd2,
        NS_DISPATCH = 2'd3
    } nsrc_e;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } stkop_e;

endpackage

// File: rtl/msq_cond_mux.sv
`timescale 1ns/1ps
module msq_cond_mux #(
    parameter int NCOND = 8
) (
    input  logic [NCOND-1:0]         cond_in,
    input  logic [$clog2(NCOND)-1:0] sel,
    input  logic                     enable,
    output logic                     pass
);

    logic [NCOND-1:0] hit;

    // One-hot match of the selected input, then reduce.
    for (genvar gi = 0; gi < NCOND; gi++) begin : g_hit
        assign hit[gi] = cond_in[gi] && (sel == ($clog2(NCOND))'(gi));
    end

    assign pass = !enable || (|hit);

endmodule

// File: rtl/msq_ret_stack.sv
`timescale 1ns/1ps
module msq_ret_stack
    import msq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] top,
    output logic          full,
    output logic          empty
);

    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVLW = $clog2(DEPTH + 1);

    occ_e            state, state_n;
    stkop_e          op;
    logic [LVLW-1:0] level, level_n;
    logic [PTRW-1:0] ptr, ptr_n, ptr_inc, ptr_dec, wr_idx;
    logic            wr_en;
    logic [AW-1:0]   slot [DEPTH];

    assign ptr_inc = (ptr == PTRW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    assign ptr_dec = (ptr == '0) ? PTRW'(DEPTH - 1) : ptr - 1'b1;

    always_comb begin
        unique case ({push, pop})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_HOLD;
        endcase
    end

    // Next-state, level, pointer and write-port logic
    always_comb begin
        state_n = state;
        level_n = level;
        ptr_n   = ptr;
        wr_en   = 1'b0;
        wr_idx  = ptr;
        unique case (state)
            OCC_EMPTY: begin
                unique case (op)
                    OP_PUSH: begin
                        ptr_n   = ptr_inc;
                        wr_idx  = ptr_inc;
                        wr_en   = 1'b1;
                        level_n = LVLW'(1);
                        state_n = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                    end
                    OP_SWAP: begin
                        wr_en   = 1'b1;
                        level_n = LVLW'(1);
                        state_n = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                    end
                    default: ;
                endcase
            end
            OCC_PARTIAL: begin
                unique case (op)
                    OP_PUSH: begin
                        ptr_n   = ptr_inc;
                        wr_idx  = ptr_inc;
                        wr_en   = 1'b1;
                        level_n = level + 1'b1;
                        state_n = (level_n == LVLW'(DEPTH)) ? OCC_FULL : OCC_PARTIAL;
                    end
                    OP_POP: begin
                        level_n = level - 1'b1;
                        if (level == LVLW'(1)) begin
                            state_n = OCC_EMPTY;
                        end else begin
                            ptr_n = ptr_dec;
                        end
                    end
                    OP_SWAP: wr_en = 1'b1;
                    default: ;
                endcase
            end
            OCC_FULL: begin
                unique case (op)
                    OP_PUSH: begin
                        ptr_n  = ptr_inc;
                        wr_idx = ptr_inc;
                        wr_en  = 1'b1;
                    end
                    OP_POP: begin
                        level_n = level - 1'b1;
                        if (level == LVLW'(1)) begin
                            state_n = OCC_EMPTY;
                        end else begin
                            ptr_n   = ptr_dec;
                            state_n = OCC_PARTIAL;
                        end
                    end
                    OP_SWAP: wr_en = 1'b1;
                    default: ;
                endcase
            end
            default: state_n = OCC_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            level <= '0;
            ptr   <= '0;
        end else begin
            state <= state_n;
            level <= level_n;
            ptr   <= ptr_n;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[gi] <= '0;
            end else if (wr_en && (wr_idx == PTRW'(gi))) begin
                slot[gi] <= wr_data;
            end
        end
    end

    // Outputs
    always_comb begin
        top   = slot[ptr];
        full  = (state == OCC_FULL);
        empty = (state == OCC_EMPTY);
    end

    p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= LVLW'(DEPTH)) && (full == (level == LVLW'(DEPTH))) && (empty == (level == '0)));

    p_push_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (level == $past(level) + 1'b1));

    p_full_push_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> full);

    p_empty_pop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (empty && $stable(top)));

    p_swap_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty) |=> $stable(level));

endmodule

// File: rtl/msq_addr_mux.sv
`timescale 1ns/1ps
module msq_addr_mux
    import msq_pkg::*;
#(
    parameter int AW = 8
) (
    input  nsrc_e         src,
    input  logic          branch_ok,
    input  logic [AW-1:0] upc,
    input  logic [AW-1:0] branch_addr,
    input  logic [AW-1:0] stack_top,
    input  logic [AW-1:0] dispatch_addr,
    output logic [AW-1:0] addr
);

    always_comb begin
        unique case (src)
            NS_UPC:      addr = upc;
            NS_BRANCH:   addr = branch_ok ? branch_addr : upc;
            NS_STACK:    addr = stack_top;
            NS_DISPATCH: addr = dispatch_addr;
            default:     addr = upc;
        endcase
    end

endmodule

// File: rtl/msq_sequencer.sv
`timescale 1ns/1ps
module msq_sequencer
    import msq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 4,
    parameter int NCOND = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               src_sel,
    input  logic                     cond_en,
    input  logic [$clog2(NCOND)-1:0] cond_sel,
    input  logic [NCOND-1:0]         cond_in,
    input  logic [AW-1:0]            branch_addr,
    input  logic [AW-1:0]            dispatch_addr,
    input  logic                     stk_push,
    input  logic                     stk_pop,
    output logic [AW-1:0]            next_addr,
    output logic                     stk_full,
    output logic                     stk_empty
);

    logic [AW-1:0] upc;
    logic [AW-1:0] stack_top;
    logic [AW-1:0] sel_addr;
    logic          branch_ok;
    nsrc_e         src;

    assign src = nsrc_e'(src_sel);

    msq_cond_mux #(.NCOND(NCOND)) u_cond (
        .cond_in (cond_in),
        .sel     (cond_sel),
        .enable  (cond_en),
        .pass    (branch_ok)
    );

    msq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (stk_push),
        .pop     (stk_pop),
        .wr_data (upc),
        .top     (stack_top),
        .full    (stk_full),
        .empty   (stk_empty)
    );

    msq_addr_mux #(.AW(AW)) u_mux (
        .src           (src),
        .branch_ok     (branch_ok),
        .upc           (upc),
        .branch_addr   (branch_addr),
        .stack_top     (stack_top),
        .dispatch_addr (dispatch_addr),
        .addr          (sel_addr)
    );

    assign next_addr = rst_n ? sel_addr : '0;

    // Microprogram counter: address after the one being issued
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc <= AW'(1);
        end else begin
            upc <= next_addr + 1'b1;
        end
    end

    always_comb begin
        if (rst_n == 1'b0) begin
            a_reset_zero_r2: assert (next_addr == '0);
        end
    end

    p_upc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (upc == $past(next_addr) + 1'b1));

    p_fallthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == NS_BRANCH && cond_en && !cond_in[cond_sel]) |-> (next_addr == upc));

    p_call_saves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_push && !stk_pop) |=> (stack_top == $past(upc)));

    p_stack_pre_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (src == NS_STACK) |-> (next_addr == stack_top));

endmodule

// File: tb/msq_sequencer_bench.sv
`timescale 1ns/1ps
module msq_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       cond_en = 1'b0;
    logic [2:0] cond_sel = 3'd0;
    logic [7:0] cond_in = 8'h00;
    logic [7:0] branch_addr = 8'h00;
    logic [7:0] dispatch_addr = 8'h00;
    logic       stk_push = 1'b0;
    logic       stk_pop = 1'b0;
    logic [7:0] next_addr;
    logic       stk_full;
    logic       stk_empty;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    msq_sequencer u_msq_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_sel       (src_sel),
        .cond_en       (cond_en),
        .cond_sel      (cond_sel),
        .cond_in       (cond_in),
        .branch_addr   (branch_addr),
        .dispatch_addr (dispatch_addr),
        .stk_push      (stk_push),
        .stk_pop       (stk_pop),
        .next_addr     (next_addr),
        .stk_full      (stk_full),
        .stk_empty     (stk_empty)
    );

    // src[45:44] cen[43] csel[42:40] cin[39:32] br[31:24] dp[23:16]
    // push[15] pop[14] exp[13:6] full[5] empty[4] req[3:0]
    localparam int NV = 29;
    localparam logic [45:0] VEC [NV] = '{
        {2'd0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b0,8'h01,1'b0,1'b1,4'd3},
        {2'd1,1'b0,3'd0,8'h00,8'h40,8'h00,1'b0,1'b0,8'h40,1'b0,1'b1,4'd4},
        {2'd1,1'b1,3'd3,8'h08,8'h80,8'h00,1'b0,1'b0,8'h80,1'b0,1'b1,4'd4},
        {2'd1,1'b1,3'd3,8'hF7,8'h80,8'h00,1'b0,1'b0,8'h81,1'b0,1'b1,4'd4},
        {2'd3,1'b0,3'd0,8'h00,8'h00,8'h20,1'b0,1'b0,8'h20,1'b0,1'b1,4'd1},
        {2'd1,1'b0,3'd0,8'h00,8'h50,8'h00,1'b1,1'b0,8'h50,1'b0,1'b1,4'd5},
        {2'd0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b0,8'h51,1'b0,1'b0,4'd10},
        {2'd1,1'b0,3'd0,8'h00,8'h60,8'h00,1'b1,1'b0,8'h60,1'b0,1'b0,4'd5},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b1,8'h52,1'b0,1'b0,4'd6},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b1,8'h21,1'b0,1'b0,4'd6},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b0,8'h21,1'b0,1'b1,4'd8},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b1,8'h21,1'b0,1'b1,4'd8},
        {2'd0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b1,1'b0,8'h22,1'b0,1'b1,4'd5},
        {2'd0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b1,1'b0,8'h23,1'b0,1'b0,4'd10},
        {2'd0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b1,1'b0,8'h24,1'b0,1'b0,4'd10},
        {2'd0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b1,1'b0,8'h25,1'b0,1'b0,4'd10},
        {2'd0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b1,1'b0,8'h26,1'b1,1'b0,4'd7},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b1,8'h26,1'b1,1'b0,4'd7},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b1,8'h25,1'b0,1'b0,4'd6},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b1,8'h24,1'b0,1'b0,4'd6},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b1,8'h23,1'b0,1'b0,4'd7},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b0,8'h23,1'b0,1'b1,4'd8},
        {2'd1,1'b0,3'd0,8'h00,8'h70,8'h00,1'b1,1'b0,8'h70,1'b0,1'b1,4'd5},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b1,1'b1,8'h24,1'b0,1'b0,4'd11},
        {2'd2,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b1,8'h71,1'b0,1'b0,4'd9},
        {2'd1,1'b1,3'd0,8'h01,8'h10,8'h00,1'b0,1'b0,8'h10,1'b0,1'b1,4'd4},
        {2'd1,1'b1,3'd7,8'h7F,8'h10,8'h00,1'b0,1'b0,8'h11,1'b0,1'b1,4'd4},
        {2'd1,1'b1,3'd7,8'h80,8'hFF,8'h00,1'b0,1'b0,8'hFF,1'b0,1'b1,4'd4},
        {2'd0,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b0,8'h00,1'b0,1'b1,4'd3}
    };

    function automatic string tag(input logic [3:0] code);
        case (code)
            4'd1:    return "R1";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [45:0] v);
        src_sel       = v[45:44];
        cond_en       = v[43];
        cond_sel      = v[42:40];
        cond_in       = v[39:32];
        branch_addr   = v[31:24];
        dispatch_addr = v[23:16];
        stk_push      = v[15];
        stk_pop       = v[14];
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R2: reset holds the address at zero whatever the selection
        src_sel = 2'd1;
        branch_addr = 8'h55;
        stk_push = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R2", "next during reset", next_addr, 8'h00);
        chk("R2", "empty during reset", {7'b0, stk_empty}, 8'h01);
        chk("R2", "full during reset", {7'b0, stk_full}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            #1;
            chk(tag(VEC[i][3:0]), $sformatf("next v%0d", i), next_addr, VEC[i][13:6]);
            chk(tag(VEC[i][3:0]), $sformatf("full v%0d", i), {7'b0, stk_full}, {7'b0, VEC[i][5]});
            chk(tag(VEC[i][3:0]), $sformatf("empty v%0d", i), {7'b0, stk_empty}, {7'b0, VEC[i][4]});
            @(negedge clk);
        end

        // R2: reset in mid-run clears everything
        rst_n = 1'b0;
        src_sel = 2'd3;
        dispatch_addr = 8'h33;
        stk_push = 1'b1;
        stk_pop = 1'b0;
        #1;
        chk("R2", "next mid-run reset", next_addr, 8'h00);
        chk("R2", "empty mid-run reset", {7'b0, stk_empty}, 8'h01);
        @(negedge clk);
        #1;
        chk("R2", "next reset held", next_addr, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        src_sel = 2'd0;
        stk_push = 1'b0;
        #1;
        chk("R2", "counter after release", next_addr, 8'h01);
        @(negedge clk);
        src_sel = 2'd2;
        #1;
        chk("R2", "cleared stack entry", next_addr, 8'h00);
        chk("R2", "empty after release", {7'b0, stk_empty}, 8'h01);

        finish_run();
    end

endmodule